// File: doc/BRIEF.md
# Iterative Single-Precision Float Divider

This block divides one 32-bit binary floating-point number by another. The layout is sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0. Both operands are unpacked. Any subnormal operand is renormalised with a leading-zero count, and its exponent is moved down to match. The 24-bit significands are then divided one quotient bit per clock by a restoring shift-subtract loop. The remainder left after the loop decides the sticky bit. The result is rounded to nearest with ties to even, and packed into a normal, subnormal or special encoding.

A client waits for `busy` to be low, then holds `load` high for one clock with both operands present. The operands are taken at that rising edge and `busy` goes high at the same edge. After a fixed number of cycles `busy` drops, and `quotient` and `status` then hold the answer. The same edge that sees `busy` low may start the next division.

Top module: `fdiv_iter`

## Requirements
- R1: For finite nonzero operands whose quotient is in the normal range, `quotient` is the IEEE single-precision quotient rounded to nearest with ties to even (e.g. 0x3F800000 / 0x40400000 gives 0x3EAAAAAB), and `status` is 000.
- R2: A division starts at a rising edge where `load` is 1 and `busy` is 0. Both operands are captured there and `busy` reads 1 after that edge.
- R3: `busy` stays high for exactly LATENCY (default 67) cycles after the starting edge. `quotient` and `status` carry the new result from the edge where `busy` falls.
- R4: `load` is ignored while `busy` is 1. Neither the running result nor the completion time changes, and no extra division follows.
- R5: `quotient` and `status` change only at a completing edge. They keep the previous result while a division runs and while the block is idle.
- R6: `status` bit 2 flags NaN, bit 1 flags infinity, bit 0 flags a subnormal (exponent field 0, fraction nonzero) result. At most one bit is set.
- R7: Subnormal dividends and divisors are accepted and give the correctly rounded quotient.
- R8: Quotients below the normal range are returned as subnormals rounded to nearest-even, with status 001. A quotient that rounds to zero gives a zero with status 000.
- R9: A nonzero finite dividend over a zero divisor gives infinity with the XOR of the operand signs, encoded as exponent 0xFF and fraction 0, with status 010.
- R10: A NaN operand, zero over zero, or infinity over infinity gives 0x7FC00000 with status 100.
- R11: A finite quotient whose rounded exponent would reach 255 gives a signed infinity with status 010. An infinite dividend over a finite divisor does the same.
- R12: A zero dividend over a nonzero divisor, or a finite dividend over an infinite divisor, gives a zero signed by the XOR of the operand signs, with status 000.
- R13: The result sign is the XOR of the two operand sign bits in every non-NaN case.
- R14: While `rst` is high at a rising edge, the block clears to `busy` 0, `quotient` 0 and `status` 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Start strobe, taken only while busy is low |
| dividend | input | 32 | Numerator in single-precision format |
| divisor | input | 32 | Denominator in single-precision format |
| quotient | output | 32 | Result, valid while busy is low |
| status | output | 3 | {NaN, infinity, subnormal} result flags |
| busy | output | 1 | High while a division is in progress |

## Verification
Each result is due exactly 67 rising edges after the edge that took the operands. `busy` must already be high at the first falling edge after that start. The bench notes the cycle number of the starting edge when it issues an operation. A monitor waits for the first falling edge at which `busy` reads low again, and there compares the elapsed edge count with 67 and the outputs with the queued expectation. Checks on ignored loads and on held outputs are sampled mid-operation and one cycle after completion, so a stray restart or an early write shows up at the ports.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int QW     = SIG_W + 3;          // quotient bits incl. guard and two spare
    localparam int EW     = EXP_W + 3;          // signed working exponent width
    localparam int LZW    = $clog2(SIG_W + 1);

    localparam logic [2:0] ST_NAN = 3'b100;
    localparam logic [2:0] ST_INF = 3'b010;
    localparam logic [2:0] ST_SUB = 3'b001;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef enum logic [1:0] {CLS_ZERO, CLS_FIN, CLS_INF, CLS_NAN} opcls_e;

    typedef struct packed {
        logic                 sign;
        opcls_e               cls;
        logic signed [EW-1:0] exp;   // unbiased+bias, may drop below 1 for subnormals
        logic [SIG_W-1:0]     sig;   // normalised, MSB set when finite
    } operand_t;

    typedef enum logic [1:0] {SP_NONE, SP_NAN, SP_INF, SP_ZERO} special_e;

    function automatic logic [LZW-1:0] lead_zeros(input logic [SIG_W-1:0] v);
        logic [LZW-1:0] n;
        logic           seen;
        n    = '0;
        seen = 1'b0;
        for (int i = SIG_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (v[i]) seen = 1'b1;
                else      n = n + 1'b1;
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/fdiv_unpack.sv
module fdiv_unpack
    import fdiv_pkg::*;
(
    input  logic [31:0] word,
    output operand_t    op
);
    fp_word_t         f;
    logic [SIG_W-1:0] raw;
    logic [LZW-1:0]   lz;

    assign f = word;

    always_comb begin
        raw     = {(f.exp != '0), f.frac};
        lz      = lead_zeros(raw);
        op.sign = f.sign;
        op.sig  = raw << lz;
        op.exp  = (f.exp == '0) ? (EW'(1) - EW'(lz)) : EW'(f.exp);
        if (f.exp == '1)
            op.cls = (f.frac != '0) ? CLS_NAN : CLS_INF;
        else if (raw == '0)
            op.cls = CLS_ZERO;
        else
            op.cls = CLS_FIN;
    end
endmodule

// File: rtl/fdiv_mant_loop.sv
module fdiv_mant_loop
    import fdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step,
    input  logic [SIG_W-1:0] num_sig,
    input  logic [SIG_W-1:0] den_sig,
    output logic [QW-1:0]    quo_bits,
    output logic             rem_nz
);
    logic [SIG_W:0]   rem;
    logic [SIG_W-1:0] dvs;
    logic [SIG_W:0]   diff;
    logic             ge;
    logic [SIG_W:0]   keep;

    assign diff = rem - {1'b0, dvs};
    assign ge   = (rem >= {1'b0, dvs});
    assign keep = ge ? diff : rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem      <= '0;
            dvs      <= '0;
            quo_bits <= '0;
        end else if (start) begin
            rem      <= {1'b0, num_sig};
            dvs      <= den_sig;
            quo_bits <= '0;
        end else if (step) begin
            quo_bits <= {quo_bits[QW-2:0], ge};
            rem      <= {keep[SIG_W-1:0], 1'b0};
        end
    end

    assign rem_nz = (rem != '0);

    // partial remainder must stay below twice the divisor while stepping (R1)
    assert_rem_bound_R1: assert property (@(posedge clk) disable iff (rst)
        step |-> (rem < {dvs, 1'b0}));
endmodule

// File: rtl/fdiv_round.sv
module fdiv_round
    import fdiv_pkg::*;
(
    input  logic                 sign,
    input  logic signed [EW-1:0] bexp,
    input  logic [QW-1:0]        quo_bits,
    input  logic                 rem_nz,
    output logic [31:0]          word,
    output logic [2:0]           flags
);
    localparam int SHW = $clog2(QW + 1);
    localparam int TW  = EW + FRAC_W;
    localparam logic [TW-1:0] INF_LIM = TW'((1 << EXP_W) - 1) << FRAC_W;

    logic [QW-1:0]        n, t, mask;
    logic signed [EW-1:0] e, shs, ebase;
    logic [SHW-1:0]       sh;
    logic [SIG_W-1:0]     mant;
    logic                 guard, sticky, inc;
    logic [SIG_W:0]       r;
    logic [TW-1:0]        tot;

    always_comb begin
        if (quo_bits[QW-1]) begin
            n = quo_bits;
            e = bexp;
        end else begin
            n = {quo_bits[QW-2:0], 1'b0};
            e = bexp - EW'(1);
        end
        shs = EW'(1) - e;
        if (e >= 1)        sh = '0;
        else if (shs >= QW) sh = SHW'(QW);
        else               sh = shs[SHW-1:0];
        t      = n >> sh;
        mask   = ~({QW{1'b1}} << sh);
        mant   = t[QW-1:3];
        guard  = t[2];
        sticky = (|t[1:0]) | (|(n & mask)) | rem_nz;
        inc    = guard & (sticky | mant[0]);
        r      = {1'b0, mant} + {{SIG_W{1'b0}}, inc};
        ebase  = (e >= 1) ? (e - EW'(1)) : '0;
        tot    = {ebase, {FRAC_W{1'b0}}} + TW'(r);
        if (tot >= INF_LIM) begin
            word  = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            flags = ST_INF;
        end else begin
            word  = {sign, tot[EXP_W+FRAC_W-1:0]};
            flags = (tot[EXP_W+FRAC_W-1:FRAC_W] == '0 && tot[FRAC_W-1:0] != '0) ? ST_SUB : 3'b000;
        end
    end
endmodule

// File: rtl/fdiv_iter.sv
module fdiv_iter
    import fdiv_pkg::*;
#(
    parameter int LATENCY = 67
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] dividend,
    input  logic [31:0] divisor,
    output logic [31:0] quotient,
    output logic [2:0]  status,
    output logic        busy
);
    localparam int CW = $clog2(LATENCY + 1);

    operand_t             a_op, b_op;
    special_e             spec_d, spec_q;
    logic                 sign_q;
    logic signed [EW-1:0] bexp_q;
    logic [CW-1:0]        cnt;
    logic                 accept, step;
    logic [QW-1:0]        quo_bits;
    logic                 rem_nz;
    logic [31:0]          rnd_word;
    logic [2:0]           rnd_flags;

    fdiv_unpack u_unp_a (.word(dividend), .op(a_op));
    fdiv_unpack u_unp_b (.word(divisor),  .op(b_op));

    always_comb begin
        if (a_op.cls == CLS_NAN || b_op.cls == CLS_NAN ||
            (a_op.cls == CLS_ZERO && b_op.cls == CLS_ZERO) ||
            (a_op.cls == CLS_INF  && b_op.cls == CLS_INF))
            spec_d = SP_NAN;
        else if (a_op.cls == CLS_INF || b_op.cls == CLS_ZERO)
            spec_d = SP_INF;
        else if (a_op.cls == CLS_ZERO || b_op.cls == CLS_INF)
            spec_d = SP_ZERO;
        else
            spec_d = SP_NONE;
    end

    assign accept = load && !busy;
    assign step   = busy && (cnt < CW'(QW)) && (spec_q == SP_NONE);

    fdiv_mant_loop u_loop (
        .clk(clk), .rst(rst), .start(accept), .step(step),
        .num_sig(a_op.sig), .den_sig(b_op.sig),
        .quo_bits(quo_bits), .rem_nz(rem_nz)
    );

    fdiv_round u_round (
        .sign(sign_q), .bexp(bexp_q), .quo_bits(quo_bits), .rem_nz(rem_nz),
        .word(rnd_word), .flags(rnd_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            spec_q   <= SP_NONE;
            sign_q   <= 1'b0;
            bexp_q   <= '0;
            quotient <= '0;
            status   <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            cnt    <= '0;
            spec_q <= spec_d;
            sign_q <= a_op.sign ^ b_op.sign;
            bexp_q <= a_op.exp - b_op.exp + EW'(BIAS);
        end else if (busy) begin
            if (cnt == CW'(LATENCY - 1)) begin
                busy <= 1'b0;
                unique case (spec_q)
                    SP_NAN:  begin quotient <= 32'h7FC0_0000; status <= ST_NAN; end
                    SP_INF:  begin quotient <= {sign_q, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}; status <= ST_INF; end
                    SP_ZERO: begin quotient <= {sign_q, 31'b0}; status <= 3'b000; end
                    default: begin quotient <= rnd_word; status <= rnd_flags; end
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // independent run-length counter for the busy window
    logic [CW-1:0] chk_run;
    always_ff @(posedge clk) begin
        if (rst)       chk_run <= '0;
        else if (busy) chk_run <= chk_run + 1'b1;
        else           chk_run <= '0;
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (load && !busy) |=> busy);
    assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (chk_run == CW'(LATENCY)));
    assert_no_overrun_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (chk_run < CW'(LATENCY)));
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(quotient) && $stable(status)));
    assert_flags_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(status));
    assert_nan_code_R10: assert property (@(posedge clk) disable iff (rst)
        status[2] |-> (quotient == 32'h7FC0_0000));
    assert_inf_code_R9: assert property (@(posedge clk) disable iff (rst)
        status[1] |-> (quotient[30:0] == 31'h7F80_0000));
endmodule

// File: tb/fdiv_iter_test.sv
`timescale 1ns/1ps
module fdiv_iter_test;
    localparam int LAT = 67;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic [31:0] quotient;
    logic [2:0]  status;
    logic        busy;

    fdiv_iter #(.LATENCY(LAT)) uut (
        .clk(clk), .rst(rst), .load(load), .dividend(dividend), .divisor(divisor),
        .quotient(quotient), .status(status), .busy(busy)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [31:0] q;
        logic [2:0]  s;
        string       req;
        int          cap;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    logic [31:0] last_q = '0;
    logic        prev_busy = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // monitor: compare at the first falling edge where busy is low again
    always @(negedge clk) begin
        if (prev_busy && !busy) begin
            if (sb.size() == 0) begin
                check(1'b0, "R4", "unexpected completion", quotient, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(quotient == e.q, e.req, "quotient", quotient, e.q);
                check(status == e.s, e.req, "status", {29'b0, status}, {29'b0, e.s});
                check(cyc - e.cap == LAT, "R3", "latency", cyc - e.cap, LAT);
            end
            last_q = quotient;
        end
        prev_busy = busy;
    end

    task automatic issue(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] eq, input logic [2:0] es,
                         input string req, input bit stray);
        exp_t e;
        logic [31:0] held;
        @(negedge clk);
        dividend = a;
        divisor  = b;
        load     = 1'b1;
        held     = last_q;
        @(negedge clk);
        load = 1'b0;
        e.q = eq; e.s = es; e.req = req; e.cap = cyc;
        sb.push_back(e);
        check(busy == 1'b1, "R2", "busy after start", {31'b0, busy}, 32'h1);
        if (stray) begin
            repeat (10) @(negedge clk);
            dividend = 32'h3F80_0000;
            divisor  = 32'h0000_0000;
            load     = 1'b1;
            check(quotient == held, "R5", "held during run", quotient, held);
            @(negedge clk);
            load = 1'b0;
        end
        while (busy) @(negedge clk);
        if (stray) begin
            @(negedge clk);
            check(busy == 1'b0, "R4", "no restart from stray load", {31'b0, busy}, 32'h0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R14", "reset busy", {31'b0, busy}, 32'h0);
        check(quotient == 32'h0, "R14", "reset quotient", quotient, 32'h0);
        check(status == 3'b000, "R14", "reset status", {29'b0, status}, 32'h0);
        rst = 1'b0;

        issue(32'h40C0_0000, 32'h4040_0000, 32'h4000_0000, 3'b000, "R1", 1'b0); // 6/3
        issue(32'h3F80_0000, 32'h4040_0000, 32'h3EAA_AAAB, 3'b000, "R1", 1'b1); // 1/3 + stray
        issue(32'h4000_0000, 32'h4040_0000, 32'h3F2A_AAAB, 3'b000, "R1", 1'b0); // 2/3
        issue(32'hC0C0_0000, 32'h4040_0000, 32'hC000_0000, 3'b000, "R13", 1'b0);
        issue(32'h3F80_0000, 32'hC040_0000, 32'hBEAA_AAAB, 3'b000, "R13", 1'b0);
        issue(32'h0040_0000, 32'h0080_0000, 32'h3F00_0000, 3'b000, "R7", 1'b0);
        issue(32'h3F80_0000, 32'h0040_0000, 32'h7F00_0000, 3'b000, "R7", 1'b0);
        issue(32'h0080_0000, 32'h4000_0000, 32'h0040_0000, 3'b001, "R8", 1'b0);
        issue(32'h0000_0003, 32'h4000_0000, 32'h0000_0002, 3'b001, "R8", 1'b0); // tie to even
        issue(32'h0000_0001, 32'h4000_0000, 32'h0000_0000, 3'b000, "R8", 1'b0); // rounds to zero
        issue(32'h3F80_0000, 32'h0000_0000, 32'h7F80_0000, 3'b010, "R9", 1'b0);
        issue(32'hBF80_0000, 32'h0000_0000, 32'hFF80_0000, 3'b010, "R9", 1'b0);
        issue(32'h0000_0000, 32'h0000_0000, 32'h7FC0_0000, 3'b100, "R10", 1'b0);
        issue(32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000, 3'b100, "R10", 1'b0);
        issue(32'h7FC0_0001, 32'h3F80_0000, 32'h7FC0_0000, 3'b100, "R10", 1'b0);
        issue(32'h7F7F_FFFF, 32'h3F00_0000, 32'h7F80_0000, 3'b010, "R11", 1'b0);
        issue(32'hFF80_0000, 32'h4000_0000, 32'hFF80_0000, 3'b010, "R11", 1'b0);
        issue(32'h4000_0000, 32'h7F80_0000, 32'h0000_0000, 3'b000, "R12", 1'b0);
        issue(32'h0000_0000, 32'hC0A0_0000, 32'h8000_0000, 3'b000, "R12", 1'b0);

        // idle hold: operands move with load low, outputs must not
        dividend = 32'h4120_0000;
        divisor  = 32'h3F80_0000;
        repeat (5) @(negedge clk);
        check(quotient == 32'h8000_0000, "R5", "idle hold quotient", quotient, 32'h8000_0000);
        check(busy == 1'b0, "R5", "idle busy", {31'b0, busy}, 32'h0);
        check(sb.size() == 0, "R3", "all results seen", sb.size(), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule